// File: doc/BRIEF.md
# Secure-Aware GPIO Port Register Bank

This block is the register bank behind a set of general-purpose I/O pin groups. Each group controls 32 pins and keeps four 32-bit state words: pin direction, output level, pull enable and a per-pin security attribution. Software reaches them over a simple single-cycle register bus. The direction word and the output word each have set, clear and toggle aliases. Writing a 1 to a bit of an alias changes only that pin, so no read-modify-write sequence is ever needed, and every alias reads back the live word.

The bank turns its state into per-pin controls for the pad ring: the output level, the output enable, and a pull-up or pull-down request. For an input pin with its pull enabled, the output bit selects the pull: 1 gives a pull-up and 0 gives a pull-down. Every bus access carries a secure flag. On a non-secure access, each bit belonging to a pin attributed as secure reads as 0 and ignores the write, one bit at a time. Only a secure access can change the attribution word.

Groups repeat every 0x80 bytes of address space. Within a group, bits [6:2] of the address pick the word. Read data is registered and appears on the cycle after the request.

Top module: `sec_gpio_bank`

## Requirements
- R1: After reset, every state word of every group is 0: all pins are inputs (pin_oe=0), pin_out=0, no pull is requested, every pin is attributed secure, and bus_rdata=0.
- R2: A write to group offset 0x18 (output set) sets each output bit written as 1 and leaves each bit written as 0 unchanged.
- R3: A write to offset 0x14 clears the output bits written as 1, a write to 0x1C inverts them, and a write to 0x10 loads the output word directly.
- R4: A read request at offset 0x10, 0x14, 0x18 or 0x1C returns the current output word on bus_rdata in the cycle after the request. bus_rdata holds its value in cycles with no read request.
- R5: The direction word loads directly at offset 0x00. Offsets 0x04, 0x08 and 0x0C set, clear and toggle it with write-1 semantics, and all four offsets read back the direction word. pin_oe equals the direction word, and pin_out equals the output word.
- R6: The pull-enable word is plain read/write at offset 0x20. For a pin with direction 0 and pull enable 1, pin_pull_up equals its output bit and pin_pull_dn equals the inverse of that bit. For any other pin, both are 0.
- R7: On a write with bus_secure=0, only the bits of pins whose attribution bit is 1 (non-secure) change. The bits of secure-attributed pins keep their values.
- R8: On a read with bus_secure=0, the bits of secure-attributed pins read as 0.
- R9: The attribution word, at offset 0x24 with 1 meaning non-secure, changes only on a secure write. A write to it with bus_secure=0 has no effect.
- R10: The group index is bus_addr[AW-1:7], so groups sit 0x80 bytes apart. A write to one group leaves every other group unchanged. An index at or above NUM_GROUPS ignores writes and reads as 0.
- R11: Word offsets above 0x24 within a group read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address: group in [AW-1:7], word in [6:2] |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | 1 = secure access, 0 = non-secure |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| pin_out | output | 32*NUM_GROUPS | Output level per pin |
| pin_oe | output | 32*NUM_GROUPS | Output enable per pin |
| pin_pull_up | output | 32*NUM_GROUPS | Pull-up request per pin |
| pin_pull_dn | output | 32*NUM_GROUPS | Pull-down request per pin |

## Verification
The assertions check these rules on every cycle: the pull requests never overlap and never reach output pins, set and clear writes touch only the bits written as 1, non-secure writes leave secure-attributed pins and the attribution word untouched, non-secure reads return 0 in secure bit positions, and read data stays stable between reads. The bench's scenarios are needed for the rest. They cover how the aliases combine over a sequence of writes, direct loads, and isolation between groups. They also cover the out-of-range group and the unmapped offsets, and the whole-state effect of random mixes of secure and non-secure traffic checked against a reference model.

// File: rtl/sgp_pkg.sv
`timescale 1ns/1ps
package sgp_pkg;
  localparam int PINS = 32;
  localparam int GRP_SHIFT = 7;

  localparam logic [4:0] W_DIR    = 5'd0;
  localparam logic [4:0] W_DIRSET = 5'd1;
  localparam logic [4:0] W_DIRCLR = 5'd2;
  localparam logic [4:0] W_DIRTGL = 5'd3;
  localparam logic [4:0] W_OUT    = 5'd4;
  localparam logic [4:0] W_OUTCLR = 5'd5;
  localparam logic [4:0] W_OUTSET = 5'd6;
  localparam logic [4:0] W_OUTTGL = 5'd7;
  localparam logic [4:0] W_PULL   = 5'd8;
  localparam logic [4:0] W_ATTR   = 5'd9;

  typedef enum logic [1:0] {WK_LOAD, WK_SET, WK_CLR, WK_TGL} wr_kind_e;

  // Merge a masked write into a state word according to the alias kind.
  function automatic logic [PINS-1:0] merge_write(
      input logic [PINS-1:0] cur, input logic [PINS-1:0] data,
      input logic [PINS-1:0] mask, input wr_kind_e kind);
    logic [PINS-1:0] hit;
    hit = data & mask;
    case (kind)
      WK_LOAD: merge_write = (cur & ~mask) | hit;
      WK_SET:  merge_write = cur | hit;
      WK_CLR:  merge_write = cur & ~hit;
      default: merge_write = cur ^ hit;
    endcase
  endfunction
endpackage

// File: rtl/sgp_addr_dec.sv
`timescale 1ns/1ps
module sgp_addr_dec #(
  parameter int NG = 3,
  parameter int GW = 2,
  parameter int AW = 9
) (
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic [NG-1:0] grp_sel,
  output logic [NG-1:0] grp_wr,
  output logic [4:0]    word_off,
  output logic          rd_en
);
  logic [GW-1:0] grp_idx;
  logic [1:0]    unused_lsb;

  assign grp_idx    = addr[AW-1:sgp_pkg::GRP_SHIFT];
  assign word_off   = addr[6:2];
  assign unused_lsb = addr[1:0];
  assign rd_en      = req & ~we;

  for (genvar g = 0; g < NG; g++) begin : g_sel
    assign grp_sel[g] = req && (grp_idx == GW'(g));
    assign grp_wr[g]  = grp_sel[g] & we;
  end
endmodule

// File: rtl/sgp_group_regs.sv
`timescale 1ns/1ps
module sgp_group_regs
  import sgp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [4:0]      word_off,
  input  logic [PINS-1:0] wdata,
  input  logic            secure,
  output logic [PINS-1:0] rd_word,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] out_q,
  output logic [PINS-1:0] pull_q,
  output logic [PINS-1:0] attr_q
);
  logic [PINS-1:0] mask, raw;
  logic [PINS-1:0] dir_d, out_d, pull_d, attr_d;
  logic            dir_en, out_en, pull_en, attr_en;

  // Secure accesses see every pin; non-secure ones only non-secure pins.
  assign mask = secure ? '1 : attr_q;

  always_comb begin
    dir_d = dir_q;  out_d = out_q;  pull_d = pull_q;  attr_d = attr_q;
    dir_en = 1'b0;  out_en = 1'b0;  pull_en = 1'b0;  attr_en = 1'b0;
    if (wr_en) begin
      case (word_off)
        W_DIR:    begin dir_en = 1'b1; dir_d = merge_write(dir_q, wdata, mask, WK_LOAD); end
        W_DIRSET: begin dir_en = 1'b1; dir_d = merge_write(dir_q, wdata, mask, WK_SET);  end
        W_DIRCLR: begin dir_en = 1'b1; dir_d = merge_write(dir_q, wdata, mask, WK_CLR);  end
        W_DIRTGL: begin dir_en = 1'b1; dir_d = merge_write(dir_q, wdata, mask, WK_TGL);  end
        W_OUT:    begin out_en = 1'b1; out_d = merge_write(out_q, wdata, mask, WK_LOAD); end
        W_OUTCLR: begin out_en = 1'b1; out_d = merge_write(out_q, wdata, mask, WK_CLR);  end
        W_OUTSET: begin out_en = 1'b1; out_d = merge_write(out_q, wdata, mask, WK_SET);  end
        W_OUTTGL: begin out_en = 1'b1; out_d = merge_write(out_q, wdata, mask, WK_TGL);  end
        W_PULL:   begin pull_en = 1'b1; pull_d = merge_write(pull_q, wdata, mask, WK_LOAD); end
        W_ATTR:   begin attr_en = secure; attr_d = wdata; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      pull_q <= '0;
      attr_q <= '0;
    end else begin
      if (dir_en)  dir_q  <= dir_d;
      if (out_en)  out_q  <= out_d;
      if (pull_en) pull_q <= pull_d;
      if (attr_en) attr_q <= attr_d;
    end
  end

  always_comb begin
    case (word_off)
      W_DIR, W_DIRSET, W_DIRCLR, W_DIRTGL: raw = dir_q;
      W_OUT, W_OUTCLR, W_OUTSET, W_OUTTGL: raw = out_q;
      W_PULL:  raw = pull_q;
      W_ATTR:  raw = attr_q;
      default: raw = '0;
    endcase
    rd_word = raw & mask;
  end
endmodule

// File: rtl/sgp_pad_ctrl.sv
`timescale 1ns/1ps
module sgp_pad_ctrl #(
  parameter int N = 32
) (
  input  logic [N-1:0] dir,
  input  logic [N-1:0] out,
  input  logic [N-1:0] pull,
  output logic [N-1:0] oe,
  output logic [N-1:0] lvl,
  output logic [N-1:0] pu,
  output logic [N-1:0] pd
);
  logic [N-1:0] pull_act;
  assign pull_act = pull & ~dir;
  assign oe  = dir;
  assign lvl = out;
  assign pu  = pull_act & out;
  assign pd  = pull_act & ~out;
endmodule

// File: rtl/sec_gpio_bank.sv
`timescale 1ns/1ps
module sec_gpio_bank #(
  parameter int NUM_GROUPS = 3,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int AW = sgp_pkg::GRP_SHIFT + GW,
  localparam int NP = NUM_GROUPS * sgp_pkg::PINS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_secure,
  output logic [31:0]   bus_rdata,
  output logic [NP-1:0] pin_out,
  output logic [NP-1:0] pin_oe,
  output logic [NP-1:0] pin_pull_up,
  output logic [NP-1:0] pin_pull_dn
);
  localparam int P = sgp_pkg::PINS;

  logic [NUM_GROUPS-1:0] grp_sel, grp_wr;
  logic [4:0]            word_off;
  logic                  rd_en;
  logic [P-1:0]          rd_word [NUM_GROUPS];
  logic [NP-1:0]         dir_all, out_all, pull_all, attr_all;
  logic [31:0]           rd_mux, rdata_q;

  sgp_addr_dec #(.NG(NUM_GROUPS), .GW(GW), .AW(AW)) dec_i (
    .req(bus_req), .we(bus_we), .addr(bus_addr),
    .grp_sel(grp_sel), .grp_wr(grp_wr), .word_off(word_off), .rd_en(rd_en));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    sgp_group_regs regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(grp_wr[g]), .word_off(word_off),
      .wdata(bus_wdata), .secure(bus_secure), .rd_word(rd_word[g]),
      .dir_q(dir_all[g*P +: P]), .out_q(out_all[g*P +: P]),
      .pull_q(pull_all[g*P +: P]), .attr_q(attr_all[g*P +: P]));
  end

  sgp_pad_ctrl #(.N(NP)) pad_i (
    .dir(dir_all), .out(out_all), .pull(pull_all),
    .oe(pin_oe), .lvl(pin_out), .pu(pin_pull_up), .pd(pin_pull_dn));

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (grp_sel[g]) rd_mux = rd_mux | rd_word[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/sgp_bank_chk.sv
`timescale 1ns/1ps
module sgp_bank_chk #(
  parameter int AW = 9,
  parameter int NP = 96
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          bus_secure,
  input logic [31:0]   bus_rdata,
  input logic [NP-1:0] pin_out,
  input logic [NP-1:0] pin_oe,
  input logic [NP-1:0] pin_pull_up,
  input logic [NP-1:0] pin_pull_dn,
  input logic [NP-1:0] attr_all
);
  logic g0;
  logic wr_set0, wr_clr0, wr_ns0, wr_ns_attr, rd_ns0;
  assign g0         = bus_req && (bus_addr[AW-1:7] == '0);
  assign wr_set0    = g0 && bus_we && bus_secure && (bus_addr[6:2] == 5'd6);
  assign wr_clr0    = g0 && bus_we && bus_secure && (bus_addr[6:2] == 5'd5);
  assign wr_ns0     = g0 && bus_we && !bus_secure;
  assign wr_ns_attr = bus_req && bus_we && !bus_secure && (bus_addr[6:2] == 5'd9);
  assign rd_ns0     = g0 && !bus_we && !bus_secure;

  p_pull_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_pull_up & pin_pull_dn) == '0) && (((pin_pull_up | pin_pull_dn) & pin_oe) == '0));

  p_outset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set0 |=> ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)) &&
                ((pin_out[31:0] & ~$past(bus_wdata)) == ($past(pin_out[31:0]) & ~$past(bus_wdata))));

  p_outclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr0 |=> ((pin_out[31:0] & $past(bus_wdata)) == '0) &&
                ((pin_out[31:0] & ~$past(bus_wdata)) == ($past(pin_out[31:0]) & ~$past(bus_wdata))));

  p_ns_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ns0 |=> (((pin_out[31:0] ^ $past(pin_out[31:0])) & ~$past(attr_all[31:0])) == '0) &&
               (((pin_oe[31:0] ^ $past(pin_oe[31:0])) & ~$past(attr_all[31:0])) == '0));

  p_ns_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ns0 |=> ((bus_rdata & ~$past(attr_all[31:0])) == '0));

  p_attr_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ns_attr |=> $stable(attr_all));

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> $stable(bus_rdata));
endmodule

bind sec_gpio_bank sgp_bank_chk #(.AW(AW), .NP(NP)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
  .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .pin_pull_up(pin_pull_up), .pin_pull_dn(pin_pull_dn), .attr_all(attr_all));

// File: tb/sec_gpio_bank_tb.sv
`timescale 1ns/1ps
module sec_gpio_bank_tb_top;
  localparam int NG = 3;
  localparam int GW = 2;
  localparam int AW = 7 + GW;
  localparam int NP = NG * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req = 1'b0, bus_we = 1'b0, bus_secure = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_out, pin_oe, pin_pull_up, pin_pull_dn;

  int n_vec = 0, n_bad = 0;
  logic [31:0] m_dir [4], m_out [4], m_pull [4], m_attr [4];

  always #2.5 clk = ~clk;

  sec_gpio_bank #(.NUM_GROUPS(NG)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
    .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pull_up(pin_pull_up), .pin_pull_dn(pin_pull_dn));

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_mask(input int g, input logic s);
    return s ? 32'hFFFF_FFFF : m_attr[g];
  endfunction

  task automatic m_write(input int g, input int off, input logic [31:0] d, input logic s);
    logic [31:0] k, h;
    if (g >= NG) return;
    k = m_mask(g, s);
    h = d & k;
    case (off)
      0: m_dir[g]  = (m_dir[g] & ~k) | h;
      1: m_dir[g]  = m_dir[g] | h;
      2: m_dir[g]  = m_dir[g] & ~h;
      3: m_dir[g]  = m_dir[g] ^ h;
      4: m_out[g]  = (m_out[g] & ~k) | h;
      5: m_out[g]  = m_out[g] & ~h;
      6: m_out[g]  = m_out[g] | h;
      7: m_out[g]  = m_out[g] ^ h;
      8: m_pull[g] = (m_pull[g] & ~k) | h;
      9: if (s) m_attr[g] = d;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] m_read(input int g, input int off, input logic s);
    logic [31:0] v;
    if (g >= NG) return 32'h0;
    case (off)
      0, 1, 2, 3: v = m_dir[g];
      4, 5, 6, 7: v = m_out[g];
      8: v = m_pull[g];
      9: v = m_attr[g];
      default: v = 32'h0;
    endcase
    return v & m_mask(g, s);
  endfunction

  task automatic check_pins(input string tag);
    logic [NP-1:0] e_oe, e_out, e_pu, e_pd;
    for (int g = 0; g < NG; g++) begin
      e_oe[g*32 +: 32]  = m_dir[g];
      e_out[g*32 +: 32] = m_out[g];
      e_pu[g*32 +: 32]  = m_pull[g] & ~m_dir[g] & m_out[g];
      e_pd[g*32 +: 32]  = m_pull[g] & ~m_dir[g] & ~m_out[g];
    end
    chk({tag, " pin_oe"}, pin_oe, e_oe);
    chk({tag, " pin_out"}, pin_out, e_out);
    chk({tag, " pin_pull_up"}, pin_pull_up, e_pu);
    chk({tag, " pin_pull_dn"}, pin_pull_dn, e_pd);
  endtask

  task automatic wr(input int g, input int off, input logic [31:0] d, input logic s, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_secure = s; bus_wdata = d;
    bus_addr = AW'(g * 128 + off * 4);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    m_write(g, off, d, s);
    check_pins(tag);
  endtask

  task automatic rd(input int g, input int off, input logic s, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_secure = s;
    bus_addr = AW'(g * 128 + off * 4);
    @(negedge clk);
    bus_req = 1'b0;
    chk({tag, " rdata"}, NP'(bus_rdata), NP'(m_read(g, off, s)));
  endtask

  initial begin
    for (int g = 0; g < 4; g++) begin
      m_dir[g] = '0; m_out[g] = '0; m_pull[g] = '0; m_attr[g] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_pins("R1");
    chk("R1 rdata", NP'(bus_rdata), '0);
    rd(0, 9, 1'b1, "R1 attr");
    rd(2, 4, 1'b1, "R1 out");
    // R2: output set
    wr(0, 4, 32'h0000_00F0, 1'b1, "R3 load");
    wr(0, 6, 32'h0000_0F0F, 1'b1, "R2 set");
    wr(0, 6, 32'h0000_0000, 1'b1, "R2 set zero");
    // R4: every alias reads the output word
    rd(0, 4, 1'b1, "R4 out");
    rd(0, 5, 1'b1, "R4 clr alias");
    rd(0, 6, 1'b1, "R4 set alias");
    rd(0, 7, 1'b1, "R4 tgl alias");
    @(negedge clk);
    chk("R4 hold", NP'(bus_rdata), NP'(m_read(0, 7, 1'b1)));
    // R3: clear, toggle, direct load
    wr(0, 5, 32'h0000_00FF, 1'b1, "R3 clr");
    wr(0, 7, 32'hFF00_0F0F, 1'b1, "R3 tgl");
    wr(0, 4, 32'h1234_5678, 1'b1, "R3 load2");
    // R5: direction and its aliases
    wr(0, 0, 32'h0000_FFFF, 1'b1, "R5 load");
    wr(0, 1, 32'hF000_0000, 1'b1, "R5 set");
    wr(0, 2, 32'h0000_00FF, 1'b1, "R5 clr");
    wr(0, 3, 32'h0F0F_0F0F, 1'b1, "R5 tgl");
    rd(0, 2, 1'b1, "R5 read");
    // R6: pulls on inputs only, direction by output bit
    wr(0, 8, 32'hFFFF_FFFF, 1'b1, "R6 pull all");
    rd(0, 8, 1'b1, "R6 read");
    wr(0, 0, 32'h0000_0000, 1'b1, "R6 all inputs");
    wr(0, 8, 32'h00FF_00FF, 1'b1, "R6 pull part");
    // R7/R8/R9: attribution
    wr(0, 9, 32'h0000_FFFF, 1'b1, "R9 attr");
    wr(0, 4, 32'hFFFF_FFFF, 1'b0, "R7 ns load");
    wr(0, 5, 32'hFFFF_00FF, 1'b0, "R7 ns clr");
    wr(0, 1, 32'hFFFF_FFFF, 1'b0, "R7 ns dirset");
    rd(0, 4, 1'b0, "R8 ns out");
    rd(0, 0, 1'b0, "R8 ns dir");
    wr(0, 9, 32'hFFFF_FFFF, 1'b0, "R9 ns attr");
    rd(0, 9, 1'b1, "R9 attr kept");
    // R10: groups
    wr(1, 4, 32'hA5A5_A5A5, 1'b1, "R10 g1");
    rd(0, 4, 1'b1, "R10 g0 kept");
    rd(1, 4, 1'b1, "R10 g1 read");
    wr(3, 4, 32'hFFFF_FFFF, 1'b1, "R10 bad grp");
    rd(3, 4, 1'b1, "R10 bad grp read");
    // R11: unmapped offsets
    wr(1, 10, 32'hFFFF_FFFF, 1'b1, "R11 wr");
    rd(1, 10, 1'b1, "R11 rd");
    rd(1, 31, 1'b1, "R11 rd top");
    // random mix
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 400; i++) begin
      int g, off;
      logic s;
      g   = int'($urandom % 4);
      off = int'($urandom % 12);
      s   = ($urandom % 4) != 0;
      if ($urandom % 2 == 0) wr(g, off, $urandom, s, "RND write");
      else rd(g, off, s, "RND read");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule